// File: doc/BRIEF.md
# Angular-Rate Sensor Power-Up Sequencer

This block brings an angular-rate sensor on a serial link from power-on to a checked, ready state with no software involved. After reset, or after a pulse on `start`, it waits a fixed number of millisecond ticks. It then runs a set handshake of raw 32-bit full-duplex frames through an external frame transactor, leaving timed gaps between some of them. It checks each reply that matters. It ends by reading the sensor's fault register and either reports ready or gives a coded reason for the failure.

The transactor sees one request at a time. The block raises `xfer_req` with the outgoing word on `xfer_cmd` and holds both until `xfer_ack` pulses. In that same cycle `xfer_rsp` carries the whole 32-bit word that the sensor shifted back during the frame. Millisecond time comes from a one-cycle `ms_tick` strobe. A mismatched reply to the first frame is reported as a warning only. Failures of the later status checks or of the fault check are fatal and stop the sequence.

Top module: `powerup_check_seq`

## Requirements
- R1: After reset or a `start` pulse the block holds `xfer_req`, `seq_done`, `seq_ok`, `probe_warn` low and `fail_code` at 0. It issues the first frame only after exactly `BOOT_WAIT_MS` ticks have been counted. A tick in the same cycle as reset or `start` is not counted.
- R2: The first frame is the rate-data command with the self-check bit (bit 1) and the parity bit (bit 0) set: 0x20000003.
- R3: `probe_warn` goes to 1 if the reply to the first frame is anything other than 0x00000001, and goes to 0 if the reply equals it. In both cases the sequence continues.
- R4: The second and third frames are each preceded by exactly `GAP_WAIT_MS` ticks, counted from the cycle after the previous acknowledge. Each carries the plain rate-data command 0x20000000.
- R5: The reply to the second frame has no effect on any output.
- R6: A reply to the third frame passes when its low byte OR 0x01 equals 0xFF and bits 27:26 equal 2. If it fails, the sequence ends with `seq_done`=1, `fail_code`=1 and no further requests.
- R7: The fourth frame is 0x20000000, requested in the cycle right after the third acknowledge. It gets the same check, and a failure ends the sequence with `fail_code`=2.
- R8: The fault read then takes two frames, issued back to back. The first is the odd-parity read command for address 0x0A (0x80140000). The second is 0x00000000, and its reply carries the register in bits 20:5. A nonzero value in reply bits 16:5 ends the sequence with `fail_code`=3. Otherwise it ends with `seq_done`=1, `seq_ok`=1 and `fail_code`=0.
- R9: Once `seq_done` is high, it and `fail_code` hold until `start`. A `start` at any point restarts from the first wait.
- R10: While `xfer_req` is high and no acknowledge has arrived, `xfer_req` stays high and `xfer_cmd` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the sequence when released |
| start | input | 1 | Restart pulse for the whole sequence |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| xfer_req | output | 1 | Frame request to the transactor |
| xfer_cmd | output | 32 | Word to shift out |
| xfer_ack | input | 1 | Frame finished; `xfer_rsp` valid this cycle |
| xfer_rsp | input | 32 | Word shifted in during the frame |
| seq_done | output | 1 | Sequence ended |
| seq_ok | output | 1 | Sequence ended with the sensor ready |
| probe_warn | output | 1 | First reply was not the expected word |
| fail_code | output | 2 | 0 none, 1 third-frame check, 2 fourth-frame check, 3 fault bits set |

## Verification
The bench builds the block with `BOOT_WAIT_MS`=6 and `GAP_WAIT_MS`=3, and sends one tick every seven clocks. With these values a full handshake takes a few hundred cycles, so the bench can run many sequences. Because the gaps between ticks are much longer than the request latency, an off-by-one in either wait count is seen exactly. The bench also tests restarts during the boot wait and during the final gap, and it drives fault words whose only set bit lies just inside or just outside the checked 12-bit field.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

    localparam int FRAME_W = 32;

    typedef enum logic [3:0] {
        ST_WAIT_BOOT,
        ST_PROBE,
        ST_WAIT_A,
        ST_FLUSH,
        ST_WAIT_B,
        ST_CHECK_A,
        ST_CHECK_B,
        ST_FAULT_CMD,
        ST_FAULT_DATA,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_CHECK_A = 2'd1,
        ERR_CHECK_B = 2'd2,
        ERR_FAULT   = 2'd3
    } fail_e;

    typedef struct packed {
        logic probe_match;
        logic status_pass;
        logic fault_hit;
    } reply_flags_t;

    localparam logic [FRAME_W-1:0] CMD_RATE     = 32'h2000_0000;
    localparam logic [FRAME_W-1:0] OP_READ      = 32'h8000_0000;
    localparam logic [FRAME_W-1:0] PROBE_REPLY  = 32'h0000_0001;
    localparam int                 SELFTEST_BIT = 1;
    localparam int                 PARITY_BIT   = 0;
    localparam int                 ADDR_LSB     = 17;
    localparam logic [7:0]         FAULT_ADDR   = 8'h0A;
    localparam int                 DATA_LSB     = 5;
    localparam int                 FAULT_BITS   = 12;
    localparam logic [1:0]         STATUS_GOOD  = 2'd2;

    function automatic logic [FRAME_W-1:0] with_odd_parity(input logic [FRAME_W-1:0] w);
        logic [FRAME_W-1:0] r;
        r = w;
        if (~^w) r[PARITY_BIT] = 1'b1;
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] read_cmd(input logic [7:0] addr);
        return with_odd_parity(OP_READ | (FRAME_W'(addr) << ADDR_LSB));
    endfunction

    function automatic logic [FRAME_W-1:0] probe_cmd();
        logic [FRAME_W-1:0] w;
        w = CMD_RATE;
        w[SELFTEST_BIT] = 1'b1;
        w[PARITY_BIT]   = 1'b1;
        return w;
    endfunction

    function automatic logic status_word_ok(input logic [FRAME_W-1:0] w);
        return ((w[7:0] | 8'h01) == 8'hFF) && (w[27:26] == STATUS_GOOD);
    endfunction

endpackage

// File: rtl/ppu_tick_timer.sv
module ppu_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ppu_reply_eval.sv
module ppu_reply_eval
    import ppu_pkg::*;
(
    input  logic [FRAME_W-1:0] rsp,
    output reply_flags_t       flags
);
    logic [FAULT_BITS-1:0] fault_field;

    assign fault_field       = rsp[DATA_LSB +: FAULT_BITS];
    assign flags.probe_match = (rsp == PROBE_REPLY);
    assign flags.status_pass = status_word_ok(rsp);
    assign flags.fault_hit   = |fault_field;
endmodule

// File: rtl/ppu_seq_fsm.sv
module ppu_seq_fsm
    import ppu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               wait_over,
    input  logic               ack,
    input  reply_flags_t       flags,
    output logic               timer_clr,
    output logic               long_wait,
    output logic               req,
    output logic [FRAME_W-1:0] cmd,
    output logic               done,
    output logic               warn,
    output fail_e              fail
);
    seq_state_e state_q, state_d;
    fail_e      fail_q, fail_d;
    logic       warn_q, warn_d;

    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        warn_d  = warn_q;
        unique case (state_q)
            ST_WAIT_BOOT:  if (wait_over) state_d = ST_PROBE;
            ST_PROBE:      if (ack) begin
                               state_d = ST_WAIT_A;
                               warn_d  = !flags.probe_match;
                           end
            ST_WAIT_A:     if (wait_over) state_d = ST_FLUSH;
            ST_FLUSH:      if (ack) state_d = ST_WAIT_B;
            ST_WAIT_B:     if (wait_over) state_d = ST_CHECK_A;
            ST_CHECK_A:    if (ack) begin
                               if (flags.status_pass) begin
                                   state_d = ST_CHECK_B;
                               end else begin
                                   state_d = ST_DONE;
                                   fail_d  = ERR_CHECK_A;
                               end
                           end
            ST_CHECK_B:    if (ack) begin
                               if (flags.status_pass) begin
                                   state_d = ST_FAULT_CMD;
                               end else begin
                                   state_d = ST_DONE;
                                   fail_d  = ERR_CHECK_B;
                               end
                           end
            ST_FAULT_CMD:  if (ack) state_d = ST_FAULT_DATA;
            ST_FAULT_DATA: if (ack) begin
                               state_d = ST_DONE;
                               if (flags.fault_hit) fail_d = ERR_FAULT;
                           end
            ST_DONE:       state_d = ST_DONE;
            default:       state_d = ST_WAIT_BOOT;
        endcase
        if (start) begin
            state_d = ST_WAIT_BOOT;
            fail_d  = ERR_NONE;
            warn_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_BOOT;
            fail_q  <= ERR_NONE;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
            warn_q  <= warn_d;
        end
    end

    always_comb begin
        req = 1'b1;
        cmd = CMD_RATE;
        unique case (state_q)
            ST_PROBE:      cmd = probe_cmd();
            ST_FLUSH,
            ST_CHECK_A,
            ST_CHECK_B:    cmd = CMD_RATE;
            ST_FAULT_CMD:  cmd = read_cmd(FAULT_ADDR);
            ST_FAULT_DATA: cmd = '0;
            default: begin
                req = 1'b0;
                cmd = '0;
            end
        endcase
    end

    assign timer_clr = start || (state_d != state_q);
    assign long_wait = (state_q == ST_WAIT_BOOT);
    assign done      = (state_q == ST_DONE);
    assign warn      = warn_q;
    assign fail      = fail_q;
endmodule

// File: rtl/powerup_check_seq.sv
module powerup_check_seq
    import ppu_pkg::*;
#(
    parameter int BOOT_WAIT_MS = 100,
    parameter int GAP_WAIT_MS  = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ms_tick,
    output logic        xfer_req,
    output logic [31:0] xfer_cmd,
    input  logic        xfer_ack,
    input  logic [31:0] xfer_rsp,
    output logic        seq_done,
    output logic        seq_ok,
    output logic        probe_warn,
    output logic [1:0]  fail_code
);
    localparam int MAX_WAIT = (BOOT_WAIT_MS > GAP_WAIT_MS) ? BOOT_WAIT_MS : GAP_WAIT_MS;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1) + 1;

    localparam logic [CNT_W-1:0] BOOT_LIM = CNT_W'(BOOT_WAIT_MS);
    localparam logic [CNT_W-1:0] GAP_LIM  = CNT_W'(GAP_WAIT_MS);

    logic         timer_clr, long_wait, wait_over;
    reply_flags_t flags;
    fail_e        fail;

    ppu_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (timer_clr),
        .tick    (ms_tick),
        .limit   (long_wait ? BOOT_LIM : GAP_LIM),
        .expired (wait_over)
    );

    ppu_reply_eval u_eval (
        .rsp   (xfer_rsp),
        .flags (flags)
    );

    ppu_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wait_over (wait_over),
        .ack       (xfer_ack),
        .flags     (flags),
        .timer_clr (timer_clr),
        .long_wait (long_wait),
        .req       (xfer_req),
        .cmd       (xfer_cmd),
        .done      (seq_done),
        .warn      (probe_warn),
        .fail      (fail)
    );

    assign fail_code = fail;
    assign seq_ok    = seq_done && (fail == ERR_NONE);
endmodule

// File: rtl/powerup_check_seq_chk.sv
module powerup_check_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        ms_tick,
    input logic        xfer_req,
    input logic [31:0] xfer_cmd,
    input logic        xfer_ack,
    input logic [31:0] xfer_rsp,
    input logic        seq_done,
    input logic        seq_ok,
    input logic        probe_warn,
    input logic [1:0]  fail_code
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_ack && !start |=> xfer_req && $stable(xfer_cmd)); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !xfer_req); // R6

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> $past(xfer_ack)); // R6

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> !seq_done && !xfer_req && fail_code == 2'd0 && !probe_warn); // R9

    AST_RESULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_done && !start |=> seq_done && $stable(fail_code) && $stable(seq_ok)); // R9
endmodule

bind powerup_check_seq powerup_check_seq_chk u_chk (.*);

// File: tb/powerup_check_seq_tb.sv
module powerup_check_seq_tb;
    localparam int FW = 6;
    localparam int SW = 3;
    localparam int TP = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic        xfer_ack = 1'b0;
    logic [31:0] xfer_rsp = '0;
    logic        xfer_req, seq_done, seq_ok, probe_warn;
    logic [31:0] xfer_cmd;
    logic [1:0]  fail_code;

    int checks = 0;
    int errors = 0;
    int gcyc = 0;
    int ticks_seen = 0;

    always #2 clk = ~clk;

    powerup_check_seq #(.BOOT_WAIT_MS(FW), .GAP_WAIT_MS(SW)) u_dut (.*);

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_tick(input bit count);
        gcyc++;
        ms_tick = (gcyc % TP == 0);
        if (ms_tick && count) ticks_seen++;
    endtask

    function automatic logic [31:0] exp_cmd(input int i);
        case (i)
            0:       return 32'h2000_0003;
            4:       return 32'h8014_0000;
            5:       return 32'h0000_0000;
            default: return 32'h2000_0000;
        endcase
    endfunction

    function automatic bit tb_pass(input logic [31:0] w);
        return ((w[7:0] | 8'h01) == 8'hFF) && (w[27:26] == 2'd2);
    endfunction

    function automatic bit tb_fault(input logic [31:0] w);
        return ((w >> 5) & 32'hFFF) != 0;
    endfunction

    function automatic logic [31:0] good_word();
        logic [31:0] w;
        w = $urandom;
        w[27:26] = 2'b10;
        w[7:1] = 7'h7F;
        return w;
    endfunction

    function automatic logic [31:0] bad_word();
        logic [31:0] w;
        w = good_word();
        if ($urandom_range(0, 1) == 0) w[27:26] = 2'(($urandom_range(0, 2) + 3) % 4);
        else w[$urandom_range(1, 7)] = 1'b0;
        return w;
    endfunction

    task automatic run_seq(input bit do_start, input logic [31:0] r [6], input int stop_after);
        int n;
        int e_err;
        bit e_warn;
        int cycles;
        e_warn = (r[0] != 32'h1);
        n = 6;
        e_err = 0;
        if (!tb_pass(r[2])) begin e_err = 1; n = 3; end
        else if (!tb_pass(r[3])) begin e_err = 2; n = 4; end
        else if (tb_fault(r[5])) e_err = 3;

        if (do_start) begin
            start = 1'b1;
            drive_tick(0);
            cyc();
            start = 1'b0;
            chk(!seq_done && !xfer_req && fail_code == 0 && !probe_warn, "R9 restart clears",
                {28'd0, seq_done, xfer_req, fail_code}, 32'd0);
        end

        for (int i = 0; i < n; i++) begin
            if (i == stop_after) return;
            ticks_seen = 0;
            cycles = 0;
            do begin
                drive_tick(1);
                cyc();
                cycles++;
            end while (!xfer_req && !seq_done && cycles < 3000);
            chk(xfer_req == 1'b1, "R1 request appears", 32'(xfer_req), 32'd1);
            if (i == 0)      chk(ticks_seen == FW, "R1 boot wait ticks", ticks_seen, FW);
            else if (i < 3)  chk(ticks_seen == SW, "R4 gap wait ticks", ticks_seen, SW);
            else if (i == 3) chk(cycles == 1, "R7 fourth frame immediate", cycles, 1);
            else             chk(cycles == 1, "R8 fault frames back to back", cycles, 1);
            if (i == 0)      chk(xfer_cmd == exp_cmd(i), "R2 probe command", xfer_cmd, exp_cmd(i));
            else if (i < 4)  chk(xfer_cmd == exp_cmd(i), "R4 rate command", xfer_cmd, exp_cmd(i));
            else             chk(xfer_cmd == exp_cmd(i), "R8 fault read command", xfer_cmd, exp_cmd(i));
            repeat ($urandom_range(0, 3)) begin
                drive_tick(0);
                cyc();
                chk(xfer_req && xfer_cmd == exp_cmd(i), "R10 request held", xfer_cmd, exp_cmd(i));
            end
            xfer_ack = 1'b1;
            xfer_rsp = r[i];
            drive_tick(0);
            cyc();
            xfer_ack = 1'b0;
            xfer_rsp = $urandom;
            if (i == 0) chk(probe_warn == e_warn, "R3 probe warning", 32'(probe_warn), 32'(e_warn));
        end

        chk(seq_done == 1'b1, "R6 done at end", 32'(seq_done), 32'd1);
        if (e_err == 1)      chk(fail_code == 2'd1, "R6 third check code", fail_code, e_err);
        else if (e_err == 2) chk(fail_code == 2'd2, "R7 fourth check code", fail_code, e_err);
        else                 chk(fail_code == 2'(e_err), "R8 fault result code", fail_code, e_err);
        chk(seq_ok == (e_err == 0), "R8 ready flag", 32'(seq_ok), 32'(e_err == 0));
        chk(probe_warn == e_warn, "R5 outputs unaffected by second reply", 32'(probe_warn), 32'(e_warn));
        repeat (12) begin
            drive_tick(0);
            cyc();
            chk(seq_done && !xfer_req && fail_code == 2'(e_err), "R9 result holds",
                {29'd0, seq_done, fail_code}, {29'd1, 2'(e_err)});
        end
    endtask

    task automatic directed(input logic [31:0] r0, input logic [31:0] r2, input logic [31:0] r3,
                            input logic [31:0] r5);
        logic [31:0] r [6];
        r[0] = r0; r[1] = $urandom; r[2] = r2; r[3] = r3; r[4] = $urandom; r[5] = r5;
        run_seq(1, r, -1);
    endtask

    initial begin
        logic [31:0] r [6];
        void'($urandom(32'd20240611));
        repeat (4) begin drive_tick(0); cyc(); end
        chk(!xfer_req && !seq_done && !seq_ok && !probe_warn && fail_code == 0, "R1 reset state",
            {27'd0, xfer_req, seq_done, seq_ok, fail_code}, 32'd0);
        rst = 1'b0;
        r[0] = 32'h1; r[1] = $urandom; r[2] = 32'h0800_00FF; r[3] = 32'h0800_00FE;
        r[4] = $urandom; r[5] = 32'h0;
        run_seq(0, r, -1);

        directed(32'h0000_0003, 32'h0BFF_FFFF, 32'h0800_00FE, 32'h0);           // R3 warn only
        directed(32'h1, 32'h0800_00FD, 32'h0800_00FF, 32'h0);                    // R6 low byte
        directed(32'h1, 32'h0400_00FF, 32'h0800_00FF, 32'h0);                    // R6 status
        directed(32'h1, 32'h0800_00FF, 32'h0C00_00FF, 32'h0);                    // R7 status
        directed(32'h1, 32'h0800_00FF, 32'h0800_007F, 32'h0);                    // R7 low byte
        directed(32'h1, 32'h0800_00FF, 32'h0800_00FF, 32'h0000_0020);            // R8 bit 0
        directed(32'h1, 32'h0800_00FF, 32'h0800_00FF, 32'h0001_0000);            // R8 bit 11
        directed(32'h1, 32'h0800_00FF, 32'h0800_00FF, 32'hFFFE_001F);            // R8 outside field

        r[0] = 32'h1; r[1] = $urandom; r[2] = good_word(); r[3] = good_word();
        r[4] = $urandom; r[5] = 32'h0;
        run_seq(1, r, 0);   // R9 restart during boot wait
        run_seq(1, r, 2);   // R9 restart during gap wait
        run_seq(1, r, -1);

        for (int k = 0; k < 14; k++) begin
            r[0] = ($urandom_range(0, 2) == 0) ? $urandom : 32'h1;
            r[1] = $urandom;
            r[2] = ($urandom_range(0, 4) == 0) ? bad_word() : good_word();
            r[3] = ($urandom_range(0, 4) == 0) ? bad_word() : good_word();
            r[4] = $urandom;
            r[5] = ($urandom_range(0, 2) == 0) ? $urandom : ($urandom & 32'hFFFE_001F);
            run_seq(1, r, -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule